// File: doc/BRIEF.md
# Debug Module Register Front End

This block is the register front end of a debug module. A debug transport drives a small register interface (address, write data, read and write strobes) to control harts under debug. It holds the run-control register, the read-only status and abstract-command status words, the auto-execute mask, a parameterised instruction buffer and a set of data words. The same buffer, data words and a scratch area for abstract commands also appear in the hart's address space as three windows that sit next to each other.

The instruction buffer has one more word than the transport can write. That last word always holds the breakpoint instruction, so a buffered sequence returns to debug mode even when it has no ending of its own. Halt, resume and reset requests go to the harts as one bit per hart. The abstract command engine lives outside the block: the block sends it a one-cycle start pulse and gets back a busy level.

Turning the module on (a run-control write that takes the enable bit from 0 to 1) clears the buffer, the data words, the scratch area and the auto-execute mask. The other fields of that same write are still captured.

Top module: `dmf_front`

## Requirements
- R1: Transport address 0x20+i, for i below PROGBUF_N, reads and writes buffer word i. A write there while cmd_busy is high leaves the word unchanged.
- R2: In the hart window, the word at byte offset 4*PROGBUF_N from the buffer base always reads 32'h00100073. A hart write to it is accepted (hart_ok=1) and changes nothing.
- R3: Hart window placement. The data words start at DATA_BASE and span 4*DATA_N bytes. The buffer window spans 4+4*PROGBUF_N bytes and ends at DATA_BASE. The scratch window spans 4*ABS_N bytes and ends where the buffer window begins. Byte k of a hart access maps to address hart_addr+k, little-endian in hart_wdata and hart_rdata.
- R4: A hart access is accepted only when hart_len is 1 to 4 and every byte lies inside a single window. Otherwise hart_ok=0, hart_rdata=0 and no state changes.
- R5: The status word (address 0x11) reads 0x00400082: bit 22 flags the implicit breakpoint, bit 7 flags authenticated and bits [3:0] hold version 2. All other bits are 0.
- R6: The abstract status word (address 0x16) holds DATA_N in bits [3:0], PROGBUF_N in bits [28:24] and the cmd_busy level in bit 12. All other bits are 0.
- R7: Run control (address 0x10) has these fields: bit 0 enable, bit 1 system reset, bits [25:16] hart select, bit 29 hart reset, bit 30 resume, bit 31 halt. A write with bit 0 clear updates only the enable bit. A write with bit 0 set captures every field, and the hart select keeps only its low clog2(NHART) bits. All fields read 0 after reset.
- R8: A run-control write that takes the enable bit from 0 to 1 clears the buffer, the data words, the scratch window and the auto-execute mask. A write with enable 1 while already enabled clears nothing.
- R9: halt_req and resume_req drive only the bit of the selected hart. reset_req is all ones while system reset is set, and otherwise drives the selected hart's bit only when hart reset is set.
- R10: The auto-execute mask is at address 0x18, bits [DATA_N-1:0]. A transport read of data word i whose mask bit is set, with cmd_busy low, makes cmd_start high for exactly the next cycle. No pulse follows when the bit is clear or cmd_busy is high.
- R11: A transport access to any address not listed here raises dmi_unhandled in that cycle. A read returns 0 and a write changes nothing.
- R12: Transport address 0x04+i, for i below DATA_N, reads and writes data word i, which is the same storage the hart sees. When both sides write the same word in one cycle, the transport value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dmi_rd | input | 1 | Transport read strobe |
| dmi_wr | input | 1 | Transport write strobe |
| dmi_addr | input | 7 | Transport register address |
| dmi_wdata | input | 32 | Transport write data |
| dmi_rdata | output | 32 | Transport read data, same cycle as dmi_rd |
| dmi_unhandled | output | 1 | Access to an unimplemented address |
| hart_req | input | 1 | Hart memory access request |
| hart_we | input | 1 | Hart access is a write |
| hart_addr | input | HA_W | Hart byte address |
| hart_len | input | 3 | Access length in bytes |
| hart_wdata | input | 32 | Hart write data, byte k at hart_addr+k |
| hart_rdata | output | 32 | Hart read data, same cycle |
| hart_ok | output | 1 | Access accepted by a window |
| cmd_busy | input | 1 | Abstract command engine busy |
| cmd_start | output | 1 | One-cycle abstract command start |
| halt_req | output | NHART | Halt request per hart |
| resume_req | output | NHART | Resume request per hart |
| reset_req | output | NHART | Reset request per hart |

## Verification
The properties assume that hart_len carries its value only while hart_req is high, and that cmd_busy is steady through a transport read so that the start pulse can be traced back to the cycle before it. The bench changes every input, cmd_busy included, only on the falling edge, so each operation covers exactly one rising edge. It never raises a transport strobe and a hart request in the same cycle, except in one directed collision case. Random hart addresses are drawn from a band a few bytes wider than the three windows, and lengths from 0 to 5, so rejected accesses occur alongside accepted ones.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

    localparam logic [31:0] EBREAK_WORD = 32'h00100073;

    localparam logic [6:0] A_DATA0  = 7'h04;
    localparam logic [6:0] A_CTRL   = 7'h10;
    localparam logic [6:0] A_STATUS = 7'h11;
    localparam logic [6:0] A_ACS    = 7'h16;
    localparam logic [6:0] A_AUTO   = 7'h18;
    localparam logic [6:0] A_PB0    = 7'h20;

    typedef struct packed {
        logic halt;
        logic resume;
        logic hreset;
        logic sysrst;
        logic active;
    } ctrl_flags_t;

    typedef struct packed {
        logic        req;
        logic        we;
        logic [2:0]  len;
        logic [31:0] wdata;
    } hart_cmd_t;

    function automatic logic len_ok(logic [2:0] l);
        return (l != 3'd0) && (l <= 3'd4);
    endfunction

    function automatic logic [7:0] ebreak_byte(int n);
        return 8'(EBREAK_WORD >> (8 * (n & 3)));
    endfunction

    function automatic logic [31:0] status_word();
        logic [31:0] w;
        w       = '0;
        w[22]   = 1'b1;
        w[7]    = 1'b1;
        w[3:0]  = 4'd2;
        return w;
    endfunction

endpackage

// File: rtl/dmf_window.sv
module dmf_window
    import dmf_pkg::*;
#(
    parameter int WORDS = 4,
    parameter bit TAIL  = 1'b0,
    parameter int BASE  = 0,
    parameter int AW    = 12,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  hart_cmd_t        acc,
    input  logic [AW-1:0]    addr,
    output logic             hit,
    output logic [31:0]      rdata,
    input  logic             dmi_we,
    input  logic [IDX_W-1:0] dmi_idx,
    input  logic [31:0]      dmi_wdata,
    output logic [31:0]      dmi_word
);

    localparam int NB   = 4 * WORDS;
    localparam int SPAN = NB + (TAIL ? 4 : 0);
    localparam int MW   = (NB > 1) ? $clog2(NB) : 1;

    logic [7:0] mem [NB];

    int a_lo;
    int a_hi;
    int off;

    always_comb begin
        a_lo  = int'(addr);
        a_hi  = a_lo + int'(acc.len);
        off   = a_lo - BASE;
        hit   = acc.req && len_ok(acc.len) && (a_lo >= BASE) && (a_hi <= BASE + SPAN);
        rdata = '0;
        for (int k = 0; k < 4; k++) begin
            if (hit && (k < int'(acc.len))) begin
                if (off + k < NB)
                    rdata[8*k +: 8] = mem[MW'(off + k)];
                else
                    rdata[8*k +: 8] = ebreak_byte(off + k - NB);
            end
        end
    end

    always_comb begin
        dmi_word = '0;
        if (int'(dmi_idx) < WORDS) begin
            for (int b = 0; b < 4; b++)
                dmi_word[8*b +: 8] = mem[MW'(4 * int'(dmi_idx) + b)];
        end
    end

    always_ff @(posedge clk) begin
        for (int j = 0; j < NB; j++) begin
            if (rst || clr) begin
                mem[j] <= '0;
            end else if (dmi_we && (int'(dmi_idx) == j / 4)) begin
                mem[j] <= dmi_wdata[8*(j%4) +: 8];
            end else if (hit && acc.we) begin
                for (int k = 0; k < 4; k++) begin
                    if ((k < int'(acc.len)) && (off + k == j))
                        mem[j] <= acc.wdata[8*k +: 8];
                end
            end
        end
    end

endmodule

// File: rtl/dmf_ctrl.sv
module dmf_ctrl
    import dmf_pkg::*;
#(
    parameter int NHART  = 4,
    parameter int HSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [31:0]       wdata,
    output ctrl_flags_t       flags,
    output logic [HSEL_W-1:0] hsel,
    output logic [NHART-1:0]  halt_req,
    output logic [NHART-1:0]  resume_req,
    output logic [NHART-1:0]  reset_req
);

    logic unused_wbits;
    assign unused_wbits = ^{wdata[28:26], wdata[15:2]};

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            hsel  <= '0;
        end else if (we) begin
            flags.active <= wdata[0];
            if (wdata[0]) begin
                flags.halt   <= wdata[31];
                flags.resume <= wdata[30];
                flags.hreset <= wdata[29];
                flags.sysrst <= wdata[1];
                hsel         <= wdata[16 +: HSEL_W];
            end
        end
    end

    for (genvar h = 0; h < NHART; h++) begin : g_hart
        logic sel;
        assign sel           = (int'(hsel) == h);
        assign halt_req[h]   = flags.halt & sel;
        assign resume_req[h] = flags.resume & sel;
        assign reset_req[h]  = flags.sysrst | (flags.hreset & sel);
    end

endmodule

// File: rtl/dmf_front.sv
module dmf_front
    import dmf_pkg::*;
#(
    parameter int NHART     = 4,
    parameter int PROGBUF_N = 4,
    parameter int DATA_N    = 2,
    parameter int ABS_N     = 2,
    parameter int HA_W      = 12,
    parameter int DATA_BASE = 12'h380
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dmi_rd,
    input  logic             dmi_wr,
    input  logic [6:0]       dmi_addr,
    input  logic [31:0]      dmi_wdata,
    output logic [31:0]      dmi_rdata,
    output logic             dmi_unhandled,
    input  logic             hart_req,
    input  logic             hart_we,
    input  logic [HA_W-1:0]  hart_addr,
    input  logic [2:0]       hart_len,
    input  logic [31:0]      hart_wdata,
    output logic [31:0]      hart_rdata,
    output logic             hart_ok,
    input  logic             cmd_busy,
    output logic             cmd_start,
    output logic [NHART-1:0] halt_req,
    output logic [NHART-1:0] resume_req,
    output logic [NHART-1:0] reset_req
);

    localparam int HSEL_W   = (NHART > 1) ? $clog2(NHART) : 1;
    localparam int PB_BASE  = DATA_BASE - 4 * (PROGBUF_N + 1);
    localparam int ABS_BASE = PB_BASE - 4 * ABS_N;
    localparam int PIDX_W   = (PROGBUF_N > 1) ? $clog2(PROGBUF_N) : 1;
    localparam int DIDX_W   = (DATA_N > 1) ? $clog2(DATA_N) : 1;
    localparam int AIDX_W   = (ABS_N > 1) ? $clog2(ABS_N) : 1;

    hart_cmd_t hcmd;
    assign hcmd = '{req: hart_req, we: hart_we, len: hart_len, wdata: hart_wdata};

    // transport address decode
    int                ai;
    logic              is_data;
    logic              is_pb;
    logic [DIDX_W-1:0] didx;
    logic [PIDX_W-1:0] pidx;

    always_comb begin
        ai      = int'(dmi_addr);
        is_data = (ai >= int'(A_DATA0)) && (ai < int'(A_DATA0) + DATA_N);
        is_pb   = (ai >= int'(A_PB0)) && (ai < int'(A_PB0) + PROGBUF_N);
        didx    = DIDX_W'(ai - int'(A_DATA0));
        pidx    = PIDX_W'(ai - int'(A_PB0));
    end

    // run control
    ctrl_flags_t       flags;
    logic [HSEL_W-1:0] hsel;
    logic              ctrl_we;
    logic              dm_clr;

    assign ctrl_we = dmi_wr && (dmi_addr == A_CTRL);
    assign dm_clr  = ctrl_we && dmi_wdata[0] && !flags.active;

    dmf_ctrl #(.NHART(NHART), .HSEL_W(HSEL_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .we         (ctrl_we),
        .wdata      (dmi_wdata),
        .flags      (flags),
        .hsel       (hsel),
        .halt_req   (halt_req),
        .resume_req (resume_req),
        .reset_req  (reset_req)
    );

    // three adjacent hart-visible windows
    logic        pb_hit, data_hit, abs_hit;
    logic [31:0] pb_hrd, data_hrd, abs_hrd;
    logic [31:0] pb_word, data_word, abs_word_unused;
    logic        pb_we, data_we;

    assign pb_we   = dmi_wr && is_pb && !cmd_busy;
    assign data_we = dmi_wr && is_data;

    dmf_window #(.WORDS(PROGBUF_N), .TAIL(1'b1), .BASE(PB_BASE), .AW(HA_W)) u_pb (
        .clk (clk), .rst (rst), .clr (dm_clr),
        .acc (hcmd), .addr (hart_addr), .hit (pb_hit), .rdata (pb_hrd),
        .dmi_we (pb_we), .dmi_idx (pidx), .dmi_wdata (dmi_wdata), .dmi_word (pb_word)
    );

    dmf_window #(.WORDS(DATA_N), .TAIL(1'b0), .BASE(DATA_BASE), .AW(HA_W)) u_data (
        .clk (clk), .rst (rst), .clr (dm_clr),
        .acc (hcmd), .addr (hart_addr), .hit (data_hit), .rdata (data_hrd),
        .dmi_we (data_we), .dmi_idx (didx), .dmi_wdata (dmi_wdata), .dmi_word (data_word)
    );

    dmf_window #(.WORDS(ABS_N), .TAIL(1'b0), .BASE(ABS_BASE), .AW(HA_W)) u_abs (
        .clk (clk), .rst (rst), .clr (dm_clr),
        .acc (hcmd), .addr (hart_addr), .hit (abs_hit), .rdata (abs_hrd),
        .dmi_we (1'b0), .dmi_idx ({AIDX_W{1'b0}}), .dmi_wdata (dmi_wdata),
        .dmi_word (abs_word_unused)
    );

    assign hart_ok    = pb_hit | data_hit | abs_hit;
    assign hart_rdata = pb_hrd | data_hrd | abs_hrd;

    // auto-execute mask and start pulse
    logic [DATA_N-1:0] autoexec;

    always_ff @(posedge clk) begin
        if (rst || dm_clr)
            autoexec <= '0;
        else if (dmi_wr && (dmi_addr == A_AUTO))
            autoexec <= dmi_wdata[DATA_N-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            cmd_start <= 1'b0;
        else
            cmd_start <= dmi_rd && is_data && autoexec[didx] && !cmd_busy;
    end

    // transport read mux
    logic [31:0] rd;
    logic        impl;

    always_comb begin
        rd   = '0;
        impl = 1'b1;
        if (is_data) begin
            rd = data_word;
        end else if (is_pb) begin
            rd = pb_word;
        end else begin
            case (dmi_addr)
                A_CTRL: begin
                    rd[31]            = flags.halt;
                    rd[30]            = flags.resume;
                    rd[29]            = flags.hreset;
                    rd[16 +: HSEL_W]  = hsel;
                    rd[1]             = flags.sysrst;
                    rd[0]             = flags.active;
                end
                A_STATUS: rd = status_word();
                A_ACS: begin
                    rd[28:24] = 5'(PROGBUF_N);
                    rd[12]    = cmd_busy;
                    rd[3:0]   = 4'(DATA_N);
                end
                A_AUTO:  rd[DATA_N-1:0] = autoexec;
                default: impl = 1'b0;
            endcase
        end
    end

    assign dmi_rdata     = (dmi_rd && impl) ? rd : 32'd0;
    assign dmi_unhandled = (dmi_rd || dmi_wr) && !impl;

endmodule

// File: rtl/dmf_front_chk.sv
module dmf_front_chk #(
    parameter int NHART = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             dmi_rd,
    input logic             dmi_unhandled,
    input logic [31:0]      dmi_rdata,
    input logic             hart_req,
    input logic [2:0]       hart_len,
    input logic             hart_ok,
    input logic [31:0]      hart_rdata,
    input logic             cmd_busy,
    input logic             cmd_start,
    input logic [NHART-1:0] halt_req,
    input logic [NHART-1:0] resume_req
);

    // R10: a start pulse follows a transport read made while idle
    p_start_after_read_r10: assert property (@(posedge clk) disable iff (rst)
        cmd_start |-> ($past(dmi_rd) && !$past(cmd_busy)));

    // R9: at most one hart is asked to halt
    p_halt_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(halt_req));

    // R9: at most one hart is asked to resume
    p_resume_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(resume_req));

    // R11: unimplemented reads return zero
    p_unhandled_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (dmi_rd && dmi_unhandled) |-> (dmi_rdata == 32'd0));

    // R4: a rejected hart access returns zero
    p_reject_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (hart_req && !hart_ok) |-> (hart_rdata == 32'd0));

    // R4: a bad length is never accepted
    p_bad_len_r4: assert property (@(posedge clk) disable iff (rst)
        (hart_req && ((hart_len == 3'd0) || (hart_len > 3'd4))) |-> !hart_ok);

endmodule

bind dmf_front dmf_front_chk #(.NHART(NHART)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .dmi_rd        (dmi_rd),
    .dmi_unhandled (dmi_unhandled),
    .dmi_rdata     (dmi_rdata),
    .hart_req      (hart_req),
    .hart_len      (hart_len),
    .hart_ok       (hart_ok),
    .hart_rdata    (hart_rdata),
    .cmd_busy      (cmd_busy),
    .cmd_start     (cmd_start),
    .halt_req      (halt_req),
    .resume_req    (resume_req)
);

// File: tb/dmf_front_tb.sv
module dmf_front_tb;

    localparam int NHART = 4;
    localparam int LO    = 'h364;   // scratch window base
    localparam int PB_LO = 'h36C;   // buffer window base
    localparam int TL_LO = 'h37C;   // fixed breakpoint word
    localparam int DT_LO = 'h380;   // data window base
    localparam int HI    = 'h388;   // end of data window

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dmi_rd = 1'b0, dmi_wr = 1'b0;
    logic [6:0]  dmi_addr = '0;
    logic [31:0] dmi_wdata = '0;
    logic [31:0] dmi_rdata;
    logic        dmi_unhandled;
    logic        hart_req = 1'b0, hart_we = 1'b0;
    logic [11:0] hart_addr = '0;
    logic [2:0]  hart_len = '0;
    logic [31:0] hart_wdata = '0;
    logic [31:0] hart_rdata;
    logic        hart_ok;
    logic        cmd_busy = 1'b0;
    logic        cmd_start;
    logic [NHART-1:0] halt_req, resume_req, reset_req;

    always #2 clk = ~clk;

    dmf_front u_dut (
        .clk (clk), .rst (rst),
        .dmi_rd (dmi_rd), .dmi_wr (dmi_wr), .dmi_addr (dmi_addr), .dmi_wdata (dmi_wdata),
        .dmi_rdata (dmi_rdata), .dmi_unhandled (dmi_unhandled),
        .hart_req (hart_req), .hart_we (hart_we), .hart_addr (hart_addr), .hart_len (hart_len),
        .hart_wdata (hart_wdata), .hart_rdata (hart_rdata), .hart_ok (hart_ok),
        .cmd_busy (cmd_busy), .cmd_start (cmd_start),
        .halt_req (halt_req), .resume_req (resume_req), .reset_req (reset_req)
    );

    int         n_chk = 0;
    int         n_bad = 0;
    bit         done  = 1'b0;
    logic       bz    = 1'b0;
    logic [7:0] mdl [HI-LO];

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic int win_of(int a);
        if (a >= LO && a < PB_LO) return 0;
        if (a >= PB_LO && a < DT_LO) return 1;
        if (a >= DT_LO && a < HI) return 2;
        return -1;
    endfunction

    function automatic logic [7:0] mbyte(int a);
        if (a >= TL_LO && a < TL_LO + 4) return 8'(32'h00100073 >> (8 * (a - TL_LO)));
        return mdl[a - LO];
    endfunction

    function automatic logic [31:0] mword(int a);
        return {mbyte(a + 3), mbyte(a + 2), mbyte(a + 1), mbyte(a)};
    endfunction

    task automatic put_word(int a, logic [31:0] w);
        for (int b = 0; b < 4; b++) mdl[a - LO + b] = w[8*b +: 8];
    endtask

    task automatic clear_model();
        for (int i = 0; i < HI - LO; i++) mdl[i] = 8'h00;
    endtask

    task automatic idle();
        @(negedge clk);
        dmi_rd = 0; dmi_wr = 0; hart_req = 0; hart_we = 0; cmd_busy = bz;
        #1;
    endtask

    task automatic dmi_w(logic [6:0] a, logic [31:0] d);
        @(negedge clk);
        dmi_rd = 0; dmi_wr = 1; dmi_addr = a; dmi_wdata = d;
        hart_req = 0; hart_we = 0; cmd_busy = bz;
        #1;
    endtask

    task automatic dmi_r(logic [6:0] a, logic [31:0] exp, string req);
        @(negedge clk);
        dmi_rd = 1; dmi_wr = 0; dmi_addr = a;
        hart_req = 0; hart_we = 0; cmd_busy = bz;
        #1;
        chk(req, dmi_rdata, exp);
    endtask

    task automatic hart(logic we, int a, int len, logic [31:0] wd, string req);
        logic        eok;
        logic [31:0] erd;
        @(negedge clk);
        dmi_rd = 0; dmi_wr = 0;
        hart_req = 1; hart_we = we; hart_addr = 12'(a); hart_len = 3'(len);
        hart_wdata = wd; cmd_busy = bz;
        #1;
        eok = (len >= 1) && (len <= 4) && (win_of(a) != -1) && (win_of(a) == win_of(a + len - 1));
        erd = '0;
        if (eok) for (int k = 0; k < len; k++) erd[8*k +: 8] = mbyte(a + k);
        chk({req, " ok"}, {31'd0, hart_ok}, {31'd0, eok});
        chk({req, " rdata"}, hart_rdata, erd);
        if (eok && we) begin
            for (int k = 0; k < len; k++)
                if (!(a + k >= TL_LO && a + k < TL_LO + 4)) mdl[a + k - LO] = wd[8*k +: 8];
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got %h expected %h", 32'd0, 32'd1);
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5eed));
        clear_model();
        repeat (3) @(negedge clk);
        rst = 0;

        // reset state
        dmi_r(7'h11, 32'h0040_0082, "R5 status");
        dmi_r(7'h16, 32'h0400_0002, "R6 abstract status");
        dmi_r(7'h10, 32'h0, "R7 control reset");
        dmi_r(7'h18, 32'h0, "R10 autoexec reset");
        idle();
        chk("R9 halt reset", {28'd0, halt_req}, 32'h0);
        chk("R9 reset_req reset", {28'd0, reset_req}, 32'h0);
        chk("R10 start reset", {31'd0, cmd_start}, 32'h0);

        // run control fields
        dmi_w(7'h10, 32'h8006_0001);
        idle();
        chk("R9 halt select", {28'd0, halt_req}, 32'h4);
        dmi_r(7'h10, 32'h8002_0001, "R7 select masked");
        dmi_w(7'h10, 32'h0000_0002);
        idle();
        chk("R9 halt kept", {28'd0, halt_req}, 32'h4);
        chk("R9 no sysreset", {28'd0, reset_req}, 32'h0);
        dmi_r(7'h10, 32'h8002_0000, "R7 disabled write");
        dmi_w(7'h10, 32'h0003_0003);
        idle();
        chk("R9 sysreset all", {28'd0, reset_req}, 32'hF);
        chk("R9 halt cleared", {28'd0, halt_req}, 32'h0);
        dmi_w(7'h10, 32'h2001_0001);
        idle();
        chk("R9 hart reset", {28'd0, reset_req}, 32'h2);
        dmi_w(7'h10, 32'h4000_0001);
        idle();
        chk("R9 resume", {28'd0, resume_req}, 32'h1);
        dmi_r(7'h10, 32'h4000_0001, "R7 resume field");

        // buffer words
        for (int i = 0; i < 4; i++) begin
            logic [31:0] w = $urandom;
            dmi_w(7'(32'h20 + i), w);
            put_word(PB_LO + 4 * i, w);
        end
        for (int i = 0; i < 4; i++) dmi_r(7'(32'h20 + i), mword(PB_LO + 4 * i), "R1 buffer");
        bz = 1;
        dmi_w(7'h21, 32'hDEAD_BEEF);
        dmi_r(7'h16, 32'h0400_1002, "R6 busy bit");
        bz = 0;
        dmi_r(7'h21, mword(PB_LO + 4), "R1 busy write ignored");

        // data words
        dmi_w(7'h04, 32'h1122_3344); put_word(DT_LO, 32'h1122_3344);
        dmi_w(7'h05, 32'hA5A5_0F0F); put_word(DT_LO + 4, 32'hA5A5_0F0F);
        dmi_r(7'h05, 32'hA5A5_0F0F, "R12 data word");
        hart(0, DT_LO, 4, 0, "R12 hart sees data");
        hart(0, DT_LO + 1, 2, 0, "R3 byte lanes");
        hart(1, DT_LO + 5, 1, 32'h77, "R3 byte write");
        dmi_r(7'h05, mword(DT_LO + 4), "R3 byte write seen");

        // fixed breakpoint word
        hart(0, TL_LO, 4, 0, "R2 tail read");
        hart(1, TL_LO, 4, 32'h0, "R2 tail write");
        hart(0, TL_LO, 4, 0, "R2 tail unchanged");

        // placement and rejection
        hart(1, PB_LO, 4, 32'hCAFE_F00D, "R3 buffer via hart");
        dmi_r(7'h20, 32'hCAFE_F00D, "R3 buffer placement");
        hart(1, LO, 4, 32'h0BAD_CAFE, "R3 scratch write");
        hart(0, LO, 4, 0, "R3 scratch read");
        hart(1, TL_LO + 2, 4, 32'hFFFF_FFFF, "R4 straddle");
        dmi_r(7'h04, mword(DT_LO), "R4 straddle no change");
        hart(1, LO - 2, 4, 32'hFFFF_FFFF, "R4 below range");
        hart(0, DT_LO, 0, 0, "R4 zero length");
        hart(0, DT_LO, 5, 0, "R4 long length");
        hart(1, HI - 2, 4, 32'hFFFF_FFFF, "R4 above range");
        dmi_r(7'h05, mword(DT_LO + 4), "R4 top no change");

        // collision
        @(negedge clk);
        dmi_rd = 0; dmi_wr = 1; dmi_addr = 7'h04; dmi_wdata = 32'h600D_0001;
        hart_req = 1; hart_we = 1; hart_addr = 12'(DT_LO); hart_len = 3'd4;
        hart_wdata = 32'hBAD0_0002; cmd_busy = 0;
        #1;
        put_word(DT_LO, 32'h600D_0001);
        dmi_r(7'h04, 32'h600D_0001, "R12 transport wins");

        // auto-execute
        dmi_w(7'h18, 32'h2);
        dmi_r(7'h18, 32'h2, "R10 mask readback");
        dmi_r(7'h05, mword(DT_LO + 4), "R10 read");
        idle();
        chk("R10 pulse", {31'd0, cmd_start}, 32'h1);
        idle();
        chk("R10 pulse one cycle", {31'd0, cmd_start}, 32'h0);
        dmi_r(7'h04, mword(DT_LO), "R10 read unmasked");
        idle();
        chk("R10 no pulse unmasked", {31'd0, cmd_start}, 32'h0);
        bz = 1;
        dmi_r(7'h05, mword(DT_LO + 4), "R10 read busy");
        bz = 0;
        idle();
        chk("R10 no pulse busy", {31'd0, cmd_start}, 32'h0);

        // unimplemented
        dmi_r(7'h7F, 32'h0, "R11 read zero");
        chk("R11 unhandled read", {31'd0, dmi_unhandled}, 32'h1);
        dmi_w(7'h24, 32'hFFFF_FFFF);
        chk("R11 unhandled write", {31'd0, dmi_unhandled}, 32'h1);
        hart(0, TL_LO, 4, 0, "R11 tail untouched");
        dmi_r(7'h23, mword(PB_LO + 12), "R11 buffer untouched");

        // enable edge clears
        dmi_w(7'h10, 32'h1);
        dmi_r(7'h20, mword(PB_LO), "R8 no clear when enabled");
        dmi_w(7'h10, 32'h0);
        dmi_w(7'h10, 32'h1);
        clear_model();
        dmi_r(7'h20, 32'h0, "R8 buffer cleared");
        dmi_r(7'h04, 32'h0, "R8 data cleared");
        dmi_r(7'h18, 32'h0, "R8 mask cleared");
        hart(0, LO, 4, 0, "R8 scratch cleared");

        // random mix
        for (int it = 0; it < 400; it++) begin
            int sel = int'($urandom_range(0, 5));
            case (sel)
                0: begin
                    int i = int'($urandom_range(0, 3));
                    logic [31:0] w = $urandom;
                    bz = ($urandom_range(0, 3) == 0);
                    dmi_w(7'(32'h20 + i), w);
                    if (!bz) put_word(PB_LO + 4 * i, w);
                    bz = 0;
                end
                1: begin
                    int i = int'($urandom_range(0, 1));
                    logic [31:0] w = $urandom;
                    dmi_w(7'(32'h04 + i), w);
                    put_word(DT_LO + 4 * i, w);
                end
                2: begin
                    int i = int'($urandom_range(0, 3));
                    dmi_r(7'(32'h20 + i), mword(PB_LO + 4 * i), "R1 random");
                end
                3: begin
                    int i = int'($urandom_range(0, 1));
                    dmi_r(7'(32'h04 + i), mword(DT_LO + 4 * i), "R12 random");
                end
                default: begin
                    int a = int'($urandom_range(LO - 4, HI + 3));
                    int l = int'($urandom_range(0, 5));
                    hart(1'($urandom_range(0, 1)), a, l, $urandom, "R4 random");
                end
            endcase
        end

        idle();
        done = 1;
        summary();
        $finish;
    end

endmodule